// File: doc/BRIEF.md
# Strap-Configured Audio Clock Master

This block produces the bit clock and the frame clock of an audio serial port from a master clock. The two clock pads share a pin each with a configuration strap. After reset is released, both pads are inputs. Their levels are filtered and then frozen. From then on, the block drives both pads as clock outputs.

The strap on the frame-clock pad chooses single or double speed. The strap on the bit-clock pad chooses the ratio family: 256x or 384x of the master clock per frame. A prescale-enable input makes one effective clock tick out of every two master-clock cycles. This lets the doubled ratios (512x and 768x) run through the same divider chain as the base ratios.

The bit clock always gives 64 periods per frame. The frame clock is low for the left half of the frame and high for the right half.

Top module: `audio_clk_master`

## Requirements
- R1: While reset is asserted, and until ready rises, `ready`, both output enables, both clock outputs and both status outputs are 0.
- R2: Starting at the first rising master-clock edge after reset release, the strap pair is sampled once per cycle. `ready`, `lrckOe` and `sclkOe` rise after the sixteenth consecutive identical sample. With steady straps, they are 1 after the 16th edge and not before.
- R3: Once ready, `dblSpeed` equals the level that was frozen from the frame-clock pad (1 = double speed). `ratio384` equals the level frozen from the bit-clock pad (1 = 384x family, 0 = 256x family).
- R4: After ready, changes on either pad input have no effect on the status outputs or on the clocks until the next reset.
- R5: The bit-clock period is N effective ticks. N is 4 (256x family) or 6 (384x family) in single speed, and 2 or 3 in double speed. An effective tick is one master-clock cycle when `preDiv` is 0, and two cycles when it is 1.
- R6: In each bit-clock period, the output is low for ceil(N/2) ticks and then high for floor(N/2) ticks.
- R7: The frame clock changes only in the cycle where the bit clock falls, once every 32 bit-clock periods. It is low during bit-clock periods 0 to 31 of each frame and high during periods 32 to 63.
- R8: In the cycle in which ready rises, both clocks are low, and bit-clock period 0 of frame 0 begins.
- R9: A sample that differs from the previous sample restarts the count of R2. A one-cycle strap glitch at edge 5 therefore moves ready to after edge 21.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| preDiv | input | 1 | Enables the divide-by-two prescaler on the master clock |
| lrckIn | input | 1 | Input level of the frame-clock pad (speed strap) |
| sclkIn | input | 1 | Input level of the bit-clock pad (ratio strap) |
| lrckOut | output | 1 | Frame clock driven to the pad |
| lrckOe | output | 1 | Output enable for the frame-clock pad |
| sclkOut | output | 1 | Bit clock driven to the pad |
| sclkOe | output | 1 | Output enable for the bit-clock pad |
| dblSpeed | output | 1 | Frozen speed strap (1 = double speed) |
| ratio384 | output | 1 | Frozen ratio strap (1 = 384x family) |
| ready | output | 1 | Straps frozen and clocks running |

## Verification
The bench uses the default parameters: a 16-cycle strap filter, 64 bit clocks per frame, and base ratios of 256 and 384. These defaults keep the largest divide at 6 ticks, so two full frames take at most 1536 master-clock cycles. The bench sweeps all eight combinations of speed strap, ratio strap and prescaler. For each one, it compares every master-clock cycle of two complete frames against values derived arithmetically from the number of elapsed ticks. Extra runs inject a strap glitch inside the filter window, and strap changes after the straps are frozen.

// File: rtl/audio_clk_master_pkg.sv
package audio_clk_master_pkg;
  typedef struct packed {
    logic run;     // clocks advance
    logic dbl;     // double speed selected
    logic ratioB;  // 384x family selected
  } clkCtrl_t;
endpackage

// File: rtl/audio_clk_master_ctrl.sv
module audio_clk_master_ctrl
  import audio_clk_master_pkg::*;
#(
  parameter int STRAP_CYCLES = 16
) (
  input  logic     mclk,
  input  logic     rstN,
  input  logic     lrckIn,
  input  logic     sclkIn,
  output clkCtrl_t ctrl,
  output logic     frozen
);
  localparam int CNT_W = $clog2(STRAP_CYCLES + 1);

  logic [1:0]       strapLast;
  logic [CNT_W-1:0] sameCnt;
  logic [1:0]       padNow;
  logic             sameAsLast;

  assign padNow     = {lrckIn, sclkIn};
  assign sameAsLast = (sameCnt != '0) && (padNow == strapLast);

  always_ff @(posedge mclk or negedge rstN) begin
    if (!rstN) begin
      strapLast <= '0;
      sameCnt   <= '0;
      frozen    <= 1'b0;
    end else if (!frozen) begin
      strapLast <= padNow;
      if (sameAsLast) begin
        sameCnt <= sameCnt + 1'b1;
        if (sameCnt == CNT_W'(STRAP_CYCLES - 1)) frozen <= 1'b1;
      end else begin
        sameCnt <= CNT_W'(1);
      end
    end
  end

  assign ctrl.run    = frozen;
  assign ctrl.dbl    = frozen & strapLast[1];
  assign ctrl.ratioB = frozen & strapLast[0];
endmodule

// File: rtl/audio_clk_master_clkgen.sv
module audio_clk_master_clkgen
  import audio_clk_master_pkg::*;
#(
  parameter int BITS_PER_FRAME = 64,
  parameter int RATIO_A        = 256,
  parameter int RATIO_B        = 384
) (
  input  logic     mclk,
  input  logic     rstN,
  input  logic     preDiv,
  input  clkCtrl_t ctrl,
  output logic     sclkOut,
  output logic     lrckOut
);
  localparam int DIV_A = RATIO_A / BITS_PER_FRAME;
  localparam int DIV_B = RATIO_B / BITS_PER_FRAME;
  localparam int DIV_MAX = (DIV_A > DIV_B) ? DIV_A : DIV_B;
  localparam int DIV_W = $clog2(DIV_MAX + 1);
  localparam int BIT_W = $clog2(BITS_PER_FRAME);

  logic             preTog;
  logic             tick;
  logic [DIV_W-1:0] divN;
  logic [DIV_W-1:0] lowLen;
  logic [DIV_W-1:0] cnt, cntNext;
  logic [BIT_W-1:0] bitIdx, bitNext;
  logic             wrap;

  always_comb begin
    divN   = ctrl.ratioB ? DIV_W'(DIV_B) : DIV_W'(DIV_A);
    if (ctrl.dbl) divN = divN >> 1;
    lowLen = divN - (divN >> 1);
  end

  assign tick = ctrl.run && (!preDiv || preTog);
  assign wrap = (cnt == divN - 1'b1);

  always_comb begin
    cntNext = cnt;
    bitNext = bitIdx;
    if (!ctrl.run) begin
      cntNext = '0;
      bitNext = '0;
    end else if (tick) begin
      if (wrap) begin
        cntNext = '0;
        bitNext = (bitIdx == BIT_W'(BITS_PER_FRAME - 1)) ? '0 : bitIdx + 1'b1;
      end else begin
        cntNext = cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge mclk or negedge rstN) begin
    if (!rstN) begin
      preTog  <= 1'b0;
      cnt     <= '0;
      bitIdx  <= '0;
      sclkOut <= 1'b0;
      lrckOut <= 1'b0;
    end else begin
      preTog  <= ctrl.run ? !preTog : 1'b0;
      cnt     <= cntNext;
      bitIdx  <= bitNext;
      sclkOut <= ctrl.run && (cntNext >= lowLen);
      lrckOut <= ctrl.run && (bitNext >= BIT_W'(BITS_PER_FRAME / 2));
    end
  end
endmodule

// File: rtl/audio_clk_master.sv
module audio_clk_master
  import audio_clk_master_pkg::*;
#(
  parameter int STRAP_CYCLES   = 16,
  parameter int BITS_PER_FRAME = 64,
  parameter int RATIO_A        = 256,
  parameter int RATIO_B        = 384
) (
  input  logic mclk,
  input  logic rstN,
  input  logic preDiv,
  input  logic lrckIn,
  input  logic sclkIn,
  output logic lrckOut,
  output logic lrckOe,
  output logic sclkOut,
  output logic sclkOe,
  output logic dblSpeed,
  output logic ratio384,
  output logic ready
);
  clkCtrl_t ctrl;
  logic     frozen;

  audio_clk_master_ctrl #(.STRAP_CYCLES(STRAP_CYCLES)) u_ctrl (
    .mclk(mclk), .rstN(rstN), .lrckIn(lrckIn), .sclkIn(sclkIn),
    .ctrl(ctrl), .frozen(frozen)
  );

  audio_clk_master_clkgen #(
    .BITS_PER_FRAME(BITS_PER_FRAME), .RATIO_A(RATIO_A), .RATIO_B(RATIO_B)
  ) u_clkgen (
    .mclk(mclk), .rstN(rstN), .preDiv(preDiv), .ctrl(ctrl),
    .sclkOut(sclkOut), .lrckOut(lrckOut)
  );

  assign ready    = frozen;
  assign lrckOe   = frozen;
  assign sclkOe   = frozen;
  assign dblSpeed = ctrl.dbl;
  assign ratio384 = ctrl.ratioB;
endmodule

// File: rtl/audio_clk_master_chk.sv
module audio_clk_master_chk (
  input logic mclk,
  input logic rstN,
  input logic ready,
  input logic sclkOut,
  input logic lrckOut,
  input logic dblSpeed,
  input logic ratio384
);
  // R1
  idle_low_chk: assert property (@(posedge mclk) disable iff (!rstN)
    !ready |-> (!sclkOut && !lrckOut && !dblSpeed && !ratio384));

  // R2
  ready_sticky_chk: assert property (@(posedge mclk) disable iff (!rstN)
    ready |=> ready);

  // R4
  status_hold_chk: assert property (@(posedge mclk) disable iff (!rstN)
    ready |=> ($stable(dblSpeed) && $stable(ratio384)));

  // R7
  frame_edge_chk: assert property (@(posedge mclk) disable iff (!rstN)
    (ready && !$stable(lrckOut)) |-> $fell(sclkOut));

  // R8
  start_phase_chk: assert property (@(posedge mclk) disable iff (!rstN)
    $rose(ready) |-> (!sclkOut && !lrckOut));
endmodule

bind audio_clk_master audio_clk_master_chk u_chk (
  .mclk(mclk), .rstN(rstN), .ready(ready), .sclkOut(sclkOut),
  .lrckOut(lrckOut), .dblSpeed(dblSpeed), .ratio384(ratio384)
);

// File: tb/test_audio_clk_master.sv
`timescale 1ns/1ps
module test_audio_clk_master;
  logic mclk = 1'b0;
  logic rstN = 1'b0;
  logic preDiv = 1'b0;
  logic lrckIn = 1'b0;
  logic sclkIn = 1'b0;
  logic lrckOut, lrckOe, sclkOut, sclkOe, dblSpeed, ratio384, ready;

  int vecs = 0;
  int errs = 0;

  always #2.5 mclk = ~mclk;

  audio_clk_master i_audio_clk_master (
    .mclk(mclk), .rstN(rstN), .preDiv(preDiv), .lrckIn(lrckIn), .sclkIn(sclkIn),
    .lrckOut(lrckOut), .lrckOe(lrckOe), .sclkOut(sclkOut), .sclkOe(sclkOe),
    .dblSpeed(dblSpeed), .ratio384(ratio384), .ready(ready)
  );

  task automatic chk(input string req, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic runCfg(input bit dbl, input bit r384, input bit pre,
                        input bit glitch, input bit lateFlip);
    int readyAt = 0;
    int n, ticks, frames;
    rstN = 1'b0;
    lrckIn = dbl; sclkIn = r384; preDiv = pre;
    repeat (3) @(negedge mclk);
    // R1: state while in reset
    chk("R1 ready", ready, 0);
    chk("R1 oe", {lrckOe, sclkOe}, 0);
    chk("R1 clocks", {lrckOut, sclkOut}, 0);
    chk("R1 status", {dblSpeed, ratio384}, 0);
    rstN = 1'b1;
    for (int k = 1; k <= 40; k++) begin
      lrckIn = (glitch && k == 5) ? !dbl : dbl;
      @(posedge mclk);
      @(negedge mclk);
      if (ready) begin readyAt = k; break; end
      // R1: before ready everything stays quiet
      chk("R1 prerdy", {lrckOe, sclkOe, lrckOut, sclkOut, dblSpeed, ratio384}, 0);
    end
    // R2 / R9: filter length
    chk(glitch ? "R9 readyEdge" : "R2 readyEdge", readyAt, glitch ? 21 : 16);
    if (readyAt == 0) return;
    chk("R2 oe", {lrckOe, sclkOe}, 3);
    // R3: status reflects straps
    chk("R3 dblSpeed", dblSpeed, dbl);
    chk("R3 ratio384", ratio384, r384);
    n = (r384 ? 6 : 4) / (dbl ? 2 : 1);
    frames = 2 * 64 * n * (pre ? 2 : 1) + 8;
    for (int j = 0; j < frames; j++) begin
      ticks = pre ? j / 2 : j;
      if (j == 0) begin
        // R8: start phase
        chk("R8 sclk", sclkOut, 0);
        chk("R8 lrck", lrckOut, 0);
      end
      // R5 R6: bit clock period and duty
      chk("R5 R6 sclk", sclkOut, ((ticks % n) >= (n - n / 2)) ? 1 : 0);
      // R7: frame clock half frames
      chk("R7 lrck", lrckOut, (((ticks / n) % 64) >= 32) ? 1 : 0);
      if (lateFlip && j == 50) begin lrckIn = !dbl; sclkIn = !r384; end
      if (lateFlip && j == 300) begin lrckIn = dbl; sclkIn = !r384; end
      @(negedge mclk);
    end
    // R4: frozen straps ignore later pad activity
    chk("R4 dblSpeed", dblSpeed, dbl);
    chk("R4 ratio384", ratio384, r384);
    chk("R4 ready", ready, 1);
  endtask

  initial begin
    #(5 * 100000);
    errs++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    for (int c = 0; c < 8; c++)
      runCfg(c[2], c[1], c[0], 1'b0, 1'b0);
    runCfg(1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    runCfg(1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    runCfg(1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    runCfg(1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule